// File: doc/BRIEF.md
# Motion-Adaptive Recursive Noise Reducer

This block filters a video stream one pixel at a time. Each incoming luma and chroma sample is blended with a delayed copy of the same picture position. The delay can be a frame, a field or a line, and it is fetched by logic outside the block. The blend moves the output toward the delayed sample by a fraction K/16 of their limited difference. Still areas are therefore averaged over time and lose noise, while areas in motion must be left alone.

Three absolute-difference detectors judge motion. One luma detector steers luma filtering. A second luma detector and a chroma detector together steer chroma filtering. Each detector turns its difference into a reduction step from 0 to 5 through a ramp that is set by an offset and a slope. The programmed K falls to zero over those five steps.

Where colour is weak and luma barely moves, chroma filtering follows the luma detector alone, which fights cross-colour. Further controls let the block:
- widen moving areas by two pixels on each side;
- treat the whole picture as moving;
- paint moving areas black for evaluation;
- switch each detector off.

Pixels outside the active picture pass through untouched.

Top module: `motion_nr`

## Requirements
- R1: While reset is asserted, y_out and c_out are 0 and out_valid is 0.
- R2: When pix_valid is high at a rising edge, the sample accepted two valid samples earlier is output, and out_valid rises after that edge. A cycle with pix_valid low leaves y_out and c_out unchanged and drops out_valid.
- R3: The filtered output is in + floor(Ke·clip(dly − in, ±8·lim)/16). The programmed K is clamped to 13 before use.
- R4: For a detector with offset o, slope s and motion m = |a − b|, the reduction step is 0 if m ≤ 4·o. Otherwise the step is min(5, floor((m − 4·o)/q)), where q is 4, 8, 16 and 16 for s = 00, 01, 10 and 11. The effective gain is Ke = floor(Kclamped·(5 − step)/5).
- R5: The luma step comes only from |y_cur − y_dly| with yl_off/yl_slope. Chroma motion has no effect on luma output.
- R6: The chroma step is the larger of two steps. The first comes from |y_cur − y_dly| with yc_off/yc_slope. The second comes from |c_cur − c_dly| with cc_off/cc_slope.
- R7: The chroma step falls back to the luma-for-chroma step alone in one case. This happens when |c_cur − 128| < 8·xc_col_ref and |y_cur − y_dly| < 4·xc_ymot_ref.
- R8: The kill bits yl_kill, yc_kill and cc_kill force the step of their detector to 0. yl_kill keeps luma filtering at full K. Killing one chroma-path detector leaves the other in sole control.
- R9: With wide_en high, each detector's step for a sample is the maximum of that detector's steps over the two samples before it, the sample itself and the two samples after it. Positions before the first sample after reset count as step 0.
- R10: With all_moving high, both final steps are 5, so active pixels leave the block unchanged.
- R11: With black_test high, an active pixel whose final luma step is 5 is output as y = 0 and c = 128.
- R12: A pixel accepted with pix_active low is output unchanged. Neither filtering nor black_test applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A sample is presented this cycle |
| pix_active | input | 1 | Sample lies in the active picture |
| y_cur | input | 8 | Current luma sample |
| y_dly | input | 8 | Delayed luma sample |
| c_cur | input | 8 | Current chroma sample, offset binary around 128 |
| c_dly | input | 8 | Delayed chroma sample |
| y_kf | input | 4 | Luma gain K (clamped to 13) |
| y_lim | input | 4 | Luma difference limit, units of 8 |
| c_kf | input | 4 | Chroma gain K (clamped to 13) |
| c_lim | input | 4 | Chroma difference limit, units of 8 |
| yl_off | input | 4 | Offset of the luma detector for luma filtering |
| yl_slope | input | 2 | Slope of the luma detector for luma filtering |
| yc_off | input | 4 | Offset of the luma detector for chroma filtering |
| yc_slope | input | 2 | Slope of the luma detector for chroma filtering |
| cc_off | input | 4 | Offset of the chroma detector |
| cc_slope | input | 2 | Slope of the chroma detector |
| xc_ymot_ref | input | 4 | Luma motion reference for the cross-colour fallback |
| xc_col_ref | input | 4 | Colour level reference for the cross-colour fallback |
| yl_kill | input | 1 | Force the luma detector for luma filtering off |
| yc_kill | input | 1 | Force the luma detector for chroma filtering off |
| cc_kill | input | 1 | Force the chroma detector off |
| wide_en | input | 1 | Widen moving areas by two samples each side |
| all_moving | input | 1 | Treat every pixel as moving |
| black_test | input | 1 | Paint fully moving pixels black |
| y_out | output | 8 | Filtered luma |
| c_out | output | 8 | Filtered chroma |
| out_valid | output | 1 | y_out and c_out were updated at the last edge |

## Verification
The bench sweeps every K value against several limits with the detectors off. This exposes a missing clamp at 13, a limiter applied on one side only, or truncation toward zero instead of floor on negative differences. Each of these would move outputs by one code or by a large amount. It also sweeps all offsets and slopes over a ramp of motion magnitudes, so an off-by-one at the offset boundary or a wrong divisor per slope shows up as a step that is one too high or one too low. Randomised streams cover every combination of the kill bits, widening, all-moving and black test, with inactive pixels and gaps mixed in. A widening window that is off-centre, a fallback that picks the wrong detector, black applied outside the picture, or output that changes during an idle cycle each produces mismatching samples.

// File: rtl/nr_pkg.sv
package nr_pkg;
    localparam int SW       = 8;   // sample width
    localparam int CFG_W    = 4;   // K, limit, offset, reference width
    localparam int SLOPE_W  = 2;
    localparam int STEP_W   = 3;
    localparam int NSTEP    = 5;   // ramp steps from full K to zero
    localparam int HALF     = 2;   // widening reach on each side
    localparam int K_MAX    = 13;
    localparam int LIM_SH   = 3;   // limit unit = 8 codes
    localparam int OFF_SH   = 2;   // offset unit = 4 codes
    localparam int XC_C_SH  = 3;   // colour reference unit
    localparam int XC_Y_SH  = 2;   // luma motion reference unit
    localparam int SH_STEEP = 2;
    localparam int SH_MID   = 3;
    localparam int SH_GENT  = 4;

    typedef logic [SW-1:0]     smp_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        smp_t  y_cur;
        smp_t  y_dly;
        smp_t  c_cur;
        smp_t  c_dly;
        logic  act;
        logic  xc_low;
        step_t r_yl;
        step_t r_yc;
        step_t r_cc;
    } tap_t;

    typedef struct packed {
        smp_t y;
        smp_t c;
        logic vld;
    } out_t;
endpackage

// File: rtl/nr_ramp.sv
module nr_ramp
    import nr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  smp_t               a,
    input  smp_t               b,
    input  logic [CFG_W-1:0]   off,
    input  logic [SLOPE_W-1:0] slope,
    input  logic               kill,
    output step_t              step
);
    smp_t mag;
    smp_t start;
    smp_t excess;
    smp_t scaled;

    always_comb begin
        mag    = (a >= b) ? (a - b) : (b - a);
        start  = SW'(off) << OFF_SH;
        excess = (mag > start) ? (mag - start) : '0;
        case (slope)
            2'd0:    scaled = excess >> SH_STEEP;
            2'd1:    scaled = excess >> SH_MID;
            default: scaled = excess >> SH_GENT;
        endcase
        if (kill)
            step = '0;
        else if (scaled > SW'(NSTEP))
            step = step_t'(NSTEP);
        else
            step = step_t'(scaled);
    end

    // R4: the step never exceeds the ramp length, and quiet motion gives no step
    assert_ramp_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step <= step_t'(NSTEP));
    assert_ramp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mag <= start) |-> (step == '0));
endmodule

// File: rtl/nr_blend.sv
module nr_blend
    import nr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  smp_t             cur,
    input  smp_t             dly,
    input  logic [CFG_W-1:0] k,
    input  logic [CFG_W-1:0] lim,
    input  step_t            step,
    output smp_t             res
);
    localparam int PW = SW + CFG_W + 2;
    localparam int NW = 7;

    logic [CFG_W-1:0]     k_cl;
    logic [NW-1:0]        k_num;
    logic [CFG_W-1:0]     k_eff;
    smp_t                 lim_u;
    logic signed [SW+1:0] diff;
    logic signed [SW+1:0] lim_s;
    logic signed [SW+1:0] clip;
    logic signed [PW-1:0] k_s;
    logic signed [PW-1:0] c_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic signed [PW-1:0] sum;
    smp_t                 lo;
    smp_t                 hi;

    always_comb begin
        k_cl  = (k > CFG_W'(K_MAX)) ? CFG_W'(K_MAX) : k;
        k_num = NW'(k_cl) * (NW'(NSTEP) - NW'(step));
        k_eff = CFG_W'(k_num / NW'(NSTEP));
        lim_u = SW'(lim) << LIM_SH;
        lim_s = $signed({2'b00, lim_u});
        diff  = $signed({2'b00, dly}) - $signed({2'b00, cur});
        if (diff > lim_s)
            clip = lim_s;
        else if (diff < -lim_s)
            clip = -lim_s;
        else
            clip = diff;
        k_s     = {{(PW-CFG_W){1'b0}}, k_eff};
        c_s     = {{(PW-SW-2){clip[SW+1]}}, clip};
        prod    = k_s * c_s;
        shifted = prod >>> CFG_W;
        sum     = $signed({{(PW-SW){1'b0}}, cur}) + shifted;
        res     = sum[SW-1:0];
        lo      = (cur < dly) ? cur : dly;
        hi      = (cur < dly) ? dly : cur;
    end

    // R3: a blend with a gain below one never leaves the span of its two inputs
    assert_blend_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res >= lo) && (res <= hi));
endmodule

// File: rtl/nr_window.sv
module nr_window
    import nr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  tap_t  din,
    input  logic  wide_en,
    output tap_t  ctr,
    output step_t w_yl,
    output step_t w_yc,
    output step_t w_cc
);
    localparam int DEPTH = 2 * HALF;

    typedef struct packed {
        tap_t [DEPTH-1:0] taps;
    } win_st_t;

    win_st_t st_d, st_q;
    tap_t    win [0:DEPTH];

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++)
                st_d.taps[i] = st_q.taps[i-1];
        end
    end

    always_comb begin
        win[0] = din;
        for (int i = 0; i < DEPTH; i++)
            win[i+1] = st_q.taps[i];
        ctr  = st_q.taps[HALF-1];
        w_yl = ctr.r_yl;
        w_yc = ctr.r_yc;
        w_cc = ctr.r_cc;
        if (wide_en) begin
            for (int i = 0; i <= DEPTH; i++) begin
                if (win[i].r_yl > w_yl) w_yl = win[i].r_yl;
                if (win[i].r_yc > w_yc) w_yc = win[i].r_yc;
                if (win[i].r_cc > w_cc) w_cc = win[i].r_cc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a widened step is never smaller than the newest sample's own step
    assert_wide_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wide_en |-> (w_yl >= din.r_yl) && (w_cc >= din.r_cc));
endmodule

// File: rtl/motion_nr.sv
module motion_nr
    import nr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               pix_active,
    input  logic [SW-1:0]      y_cur,
    input  logic [SW-1:0]      y_dly,
    input  logic [SW-1:0]      c_cur,
    input  logic [SW-1:0]      c_dly,
    input  logic [CFG_W-1:0]   y_kf,
    input  logic [CFG_W-1:0]   y_lim,
    input  logic [CFG_W-1:0]   c_kf,
    input  logic [CFG_W-1:0]   c_lim,
    input  logic [CFG_W-1:0]   yl_off,
    input  logic [SLOPE_W-1:0] yl_slope,
    input  logic [CFG_W-1:0]   yc_off,
    input  logic [SLOPE_W-1:0] yc_slope,
    input  logic [CFG_W-1:0]   cc_off,
    input  logic [SLOPE_W-1:0] cc_slope,
    input  logic [CFG_W-1:0]   xc_ymot_ref,
    input  logic [CFG_W-1:0]   xc_col_ref,
    input  logic               yl_kill,
    input  logic               yc_kill,
    input  logic               cc_kill,
    input  logic               wide_en,
    input  logic               all_moving,
    input  logic               black_test,
    output logic [SW-1:0]      y_out,
    output logic [SW-1:0]      c_out,
    output logic               out_valid
);
    localparam smp_t C_MID = smp_t'(1 << (SW - 1));

    step_t s_yl, s_yc, s_cc;
    step_t w_yl, w_yc, w_cc;
    step_t r_y, r_c;
    smp_t  ymag, c_lvl;
    smp_t  y_filt, c_filt;
    logic  xc_low;
    tap_t  new_tap, ctr;
    out_t  out_d, out_q;

    nr_ramp u_ramp_yl (.clk(clk), .rst_n(rst_n), .a(y_cur), .b(y_dly),
        .off(yl_off), .slope(yl_slope), .kill(yl_kill), .step(s_yl));
    nr_ramp u_ramp_yc (.clk(clk), .rst_n(rst_n), .a(y_cur), .b(y_dly),
        .off(yc_off), .slope(yc_slope), .kill(yc_kill), .step(s_yc));
    nr_ramp u_ramp_cc (.clk(clk), .rst_n(rst_n), .a(c_cur), .b(c_dly),
        .off(cc_off), .slope(cc_slope), .kill(cc_kill), .step(s_cc));

    always_comb begin
        ymag   = (y_cur >= y_dly) ? (y_cur - y_dly) : (y_dly - y_cur);
        c_lvl  = (c_cur >= C_MID) ? (c_cur - C_MID) : (C_MID - c_cur);
        xc_low = (c_lvl < (SW'(xc_col_ref) << XC_C_SH)) &&
                 (ymag  < (SW'(xc_ymot_ref) << XC_Y_SH));
        new_tap = '{y_cur: y_cur, y_dly: y_dly, c_cur: c_cur, c_dly: c_dly,
                    act: pix_active, xc_low: xc_low,
                    r_yl: s_yl, r_yc: s_yc, r_cc: s_cc};
    end

    nr_window u_window (.clk(clk), .rst_n(rst_n), .adv(pix_valid), .din(new_tap),
        .wide_en(wide_en), .ctr(ctr), .w_yl(w_yl), .w_yc(w_yc), .w_cc(w_cc));

    always_comb begin
        if (all_moving) begin
            r_y = step_t'(NSTEP);
            r_c = step_t'(NSTEP);
        end else begin
            r_y = w_yl;
            if (ctr.xc_low)
                r_c = w_yc;
            else
                r_c = (w_yc > w_cc) ? w_yc : w_cc;
        end
    end

    nr_blend u_blend_y (.clk(clk), .rst_n(rst_n), .cur(ctr.y_cur), .dly(ctr.y_dly),
        .k(y_kf), .lim(y_lim), .step(r_y), .res(y_filt));
    nr_blend u_blend_c (.clk(clk), .rst_n(rst_n), .cur(ctr.c_cur), .dly(ctr.c_dly),
        .k(c_kf), .lim(c_lim), .step(r_c), .res(c_filt));

    always_comb begin
        out_d     = out_q;
        out_d.vld = pix_valid;
        if (pix_valid) begin
            if (!ctr.act) begin
                out_d.y = ctr.y_cur;
                out_d.c = ctr.c_cur;
            end else if (black_test && (r_y == step_t'(NSTEP))) begin
                out_d.y = '0;
                out_d.c = C_MID;
            end else begin
                out_d.y = y_filt;
                out_d.c = c_filt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign y_out     = out_q.y;
    assign c_out     = out_q.c;
    assign out_valid = out_q.vld;

    // R2: idle cycles hold the outputs; valid follows the strobe by one edge
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(y_out) && $stable(c_out) && !out_valid);
    assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    // R12: pixels outside the picture leave unchanged
    assert_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !ctr.act) |=> (y_out == $past(ctr.y_cur)) && (c_out == $past(ctr.c_cur)));
    // R10: with everything treated as moving, active pixels leave unchanged
    assert_allmov_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && all_moving && !black_test)
        |=> (y_out == $past(ctr.y_cur)) && (c_out == $past(ctr.c_cur)));
endmodule

// File: tb/motion_nr_tb_top.sv
module motion_nr_tb_top;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_active = 1'b0;
    logic [7:0] y_cur = '0, y_dly = '0, c_cur = '0, c_dly = '0;
    logic [3:0] y_kf = '0, y_lim = '0, c_kf = '0, c_lim = '0;
    logic [3:0] yl_off = '0, yc_off = '0, cc_off = '0, xc_ymot_ref = '0, xc_col_ref = '0;
    logic [1:0] yl_slope = '0, yc_slope = '0, cc_slope = '0;
    logic yl_kill = 0, yc_kill = 0, cc_kill = 0, wide_en = 0, all_moving = 0, black_test = 0;
    logic [7:0] y_out, c_out;
    logic out_valid;

    int n_chk = 0, n_bad = 0;
    int ya[N], yb[N], ca[N], cb[N];
    bit av[N];

    always #(CLK_P/2) clk = ~clk;

    motion_nr dut_i (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_active(pix_active),
        .y_cur(y_cur), .y_dly(y_dly), .c_cur(c_cur), .c_dly(c_dly),
        .y_kf(y_kf), .y_lim(y_lim), .c_kf(c_kf), .c_lim(c_lim),
        .yl_off(yl_off), .yl_slope(yl_slope), .yc_off(yc_off), .yc_slope(yc_slope),
        .cc_off(cc_off), .cc_slope(cc_slope), .xc_ymot_ref(xc_ymot_ref), .xc_col_ref(xc_col_ref),
        .yl_kill(yl_kill), .yc_kill(yc_kill), .cc_kill(cc_kill), .wide_en(wide_en),
        .all_moving(all_moving), .black_test(black_test),
        .y_out(y_out), .c_out(c_out), .out_valid(out_valid));

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // R4 ramp arithmetic
    function automatic int ramp(int m, int off, int sl);
        int st, q, e;
        st = off * 4;
        if (m <= st) return 0;
        q = (sl == 0) ? 4 : ((sl == 1) ? 8 : 16);
        e = (m - st) / q;
        return (e > 5) ? 5 : e;
    endfunction

    function automatic int det(int which, int j);
        if (j < 0) return 0;
        case (which)
            0: return yl_kill ? 0 : ramp(absd(ya[j], yb[j]), int'(yl_off), int'(yl_slope));
            1: return yc_kill ? 0 : ramp(absd(ya[j], yb[j]), int'(yc_off), int'(yc_slope));
            default: return cc_kill ? 0 : ramp(absd(ca[j], cb[j]), int'(cc_off), int'(cc_slope));
        endcase
    endfunction

    // R9 widening over two samples either side
    function automatic int wdet(int which, int k);
        int m;
        if (!wide_en) return det(which, k);
        m = 0;
        for (int j = k - 2; j <= k + 2; j++)
            if (det(which, j) > m) m = det(which, j);
        return m;
    endfunction

    function automatic int fdiv16(int v);
        return (v >= 0) ? v / 16 : -((-v + 15) / 16);
    endfunction

    function automatic int blend(int cur, int dly, int k, int lim, int r);
        int kc, ke, d, l;
        kc = (k > 13) ? 13 : k;
        ke = (kc * (5 - r)) / 5;
        l  = lim * 8;
        d  = dly - cur;
        if (d > l) d = l;
        if (d < -l) d = -l;
        return cur + fdiv16(ke * d);
    endfunction

    task automatic expect_out(input int k, output int ey, output int ec);
        int ry, rc, a, b;
        if (k < 0) begin ey = 0; ec = 0; return; end
        if (!av[k]) begin ey = ya[k]; ec = ca[k]; return; end
        if (all_moving) begin
            ry = 5; rc = 5;
        end else begin
            ry = wdet(0, k);
            a  = wdet(1, k);
            b  = wdet(2, k);
            if (absd(ca[k], 128) < int'(xc_col_ref) * 8 && absd(ya[k], yb[k]) < int'(xc_ymot_ref) * 4)
                rc = a;
            else
                rc = (a > b) ? a : b;
        end
        if (black_test && ry == 5) begin ey = 0; ec = 128; return; end
        ey = blend(ya[k], yb[k], int'(y_kf), int'(y_lim), ry);
        ec = blend(ca[k], cb[k], int'(c_kf), int'(c_lim), rc);
    endtask

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pix_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic run_stream(string ytag, string ctag, int gap_every);
        int ey, ec, k, hy, hc;
        string ty, tc;
        do_reset();
        for (int i = 0; i < N; i++) begin
            y_cur = 8'(ya[i]); y_dly = 8'(yb[i]);
            c_cur = 8'(ca[i]); c_dly = 8'(cb[i]);
            pix_active = av[i];
            pix_valid = 1'b1;
            @(posedge clk);
            #1;
            pix_valid = 1'b0;
            k = i - 2;
            expect_out(k, ey, ec);
            ty = (k >= 0 && !av[k]) ? "R12" : ytag;
            tc = (k >= 0 && !av[k]) ? "R12" : ctag;
            check(ty, "y_out", int'(y_out), ey);
            check(tc, "c_out", int'(c_out), ec);
            check("R2", "out_valid", int'(out_valid), 1);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
                hy = int'(y_out); hc = int'(c_out);
                @(posedge clk);
                #1;
                check("R2", "y_out idle hold", int'(y_out), hy);
                check("R2", "c_out idle hold", int'(c_out), hc);
                check("R2", "out_valid idle", int'(out_valid), 0);
            end
        end
    endtask

    function automatic int clamp8(int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    task automatic fill(int mode);
        for (int i = 0; i < N; i++) begin
            case (mode)
                0: begin
                    ya[i] = 20 + i * 7;
                    yb[i] = clamp8(ya[i] + ((i * 13) % 121) - 60);
                    ca[i] = 128 + ((i * 5) % 41) - 20;
                    cb[i] = clamp8(ca[i] + ((i * 29) % 161) - 80);
                    av[i] = 1'b1;
                end
                1: begin
                    ya[i] = 60;  yb[i] = 60 + i * 6;
                    ca[i] = 128; cb[i] = 128 + i * 3;
                    av[i] = 1'b1;
                end
                default: begin
                    ya[i] = int'($urandom_range(0, 255));
                    if ($urandom_range(0, 3) == 0) yb[i] = int'($urandom_range(0, 255));
                    else yb[i] = clamp8(ya[i] + int'($urandom_range(0, 40)) - 20);
                    ca[i] = 128 + int'($urandom_range(0, 80)) - 40;
                    if ($urandom_range(0, 3) == 0) cb[i] = int'($urandom_range(0, 255));
                    else cb[i] = clamp8(ca[i] + int'($urandom_range(0, 30)) - 15);
                    av[i] = ($urandom_range(0, 7) != 0);
                end
            endcase
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "y_out reset", int'(y_out), 0);
        check("R1", "c_out reset", int'(c_out), 0);
        check("R1", "out_valid reset", int'(out_valid), 0);

        // R3 blend and limiter, detectors off
        yl_kill = 1; yc_kill = 1; cc_kill = 1;
        for (int k = 0; k < 16; k++) begin
            for (int li = 0; li < 4; li++) begin
                y_kf = 4'(k); c_kf = 4'(15 - k);
                y_lim = (li == 0) ? 4'd0 : ((li == 1) ? 4'd2 : ((li == 2) ? 4'd7 : 4'd15));
                c_lim = 4'(15 - int'(y_lim));
                fill(0);
                run_stream("R3", "R3", 0);
            end
        end

        // R4 ramp over every offset and slope
        yl_kill = 0; yc_kill = 0; cc_kill = 1;
        y_kf = 4'd13; c_kf = 4'd12; y_lim = 4'd15; c_lim = 4'd15;
        xc_ymot_ref = 4'd0; xc_col_ref = 4'd0;
        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 4; s++) begin
                yl_off = 4'(o); yl_slope = 2'(s);
                yc_off = 4'(15 - o); yc_slope = 2'(3 - s);
                fill(1);
                run_stream("R4", "R4", 0);
            end
        end

        // R5..R12 every combination of the mode bits on random streams
        for (int cfg = 0; cfg < 64; cfg++) begin
            string yt, ct;
            yl_kill = cfg[0]; yc_kill = cfg[1]; cc_kill = cfg[2];
            wide_en = cfg[3]; black_test = cfg[4]; all_moving = cfg[5];
            y_kf = 4'($urandom_range(0, 15)); c_kf = 4'($urandom_range(0, 15));
            y_lim = 4'($urandom_range(0, 15)); c_lim = 4'($urandom_range(0, 15));
            yl_off = 4'($urandom_range(0, 15)); yc_off = 4'($urandom_range(0, 15));
            cc_off = 4'($urandom_range(0, 15));
            yl_slope = 2'($urandom_range(0, 3)); yc_slope = 2'($urandom_range(0, 3));
            cc_slope = 2'($urandom_range(0, 3));
            xc_ymot_ref = 4'($urandom_range(0, 15)); xc_col_ref = 4'($urandom_range(0, 15));
            yt = all_moving ? "R10" : (black_test ? "R11" : (wide_en ? "R9" : (yl_kill ? "R8" : "R5")));
            ct = all_moving ? "R10" : (black_test ? "R11" : (wide_en ? "R9" :
                 ((yc_kill || cc_kill) ? "R8" : "R6/R7")));
            fill(2);
            run_stream(yt, ct, 7);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule